// File: doc/BRIEF.md
# Tagged Metadata Response Generator

This block answers a host's request for device metadata. It streams a self-describing list of records over a byte-wide valid/ready transmit channel. Each record opens with a key byte that says what kind of value follows and which quantity it is. The value is one of three kinds: a zero-terminated ASCII text, a four-byte unsigned integer, or a one-byte unsigned integer. A single zero key closes the list, so a receiver can parse it without knowing the record count in advance.

All record contents are fixed when the block is built, through parameters. These cover three text fields (device name, gate-array firmware version, auxiliary firmware version), the probe count, the sample memory size, the dynamic memory size, the maximum sample rate in Hz and the protocol version. A command decoder pulses the request input. The byte channel normally feeds a serial transmitter.

Top module: `meta_resp_gen`

## Requirements
- R1: While reset is held, and whenever no response is in progress, `tx_valid_o` and `busy_o` are low.
- R2: A request seen while idle makes `busy_o` and `tx_valid_o` go high on the next clock edge, with the first key byte 0x01 on `tx_data_o`.
- R3: Every key byte carries the value type in bits 7:5 and the token in bits 4:0. Text records use type 0 with tokens 1 (device name), 2 (gate-array version) and 3 (auxiliary version).
- R4: A text record sends its characters first character first, followed by one 0x00 byte.
- R5: Four-byte records use type 1, so their keys are 0x20 to 0x24. The tokens are 0 (probe count), 1 (sample memory bytes), 2 (dynamic memory bytes), 3 (maximum sample rate in Hz) and 4 (protocol version). Each value is sent most significant byte first.
- R6: One-byte records use type 2, so their keys are 0x40 and 0x41. Token 0 is the probe count and token 1 is the protocol version, each taken from the low 8 bits of its parameter.
- R7: Records go out in a fixed order: the three text records by token, then the five four-byte records by token, then the two one-byte records by token, then one 0x00 terminator key.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_valid_o` hold their values.
- R9: A request that arrives while a response is in progress has no effect. The stream continues byte for byte without restarting.
- R10: `busy_o` stays high until the terminator byte has been accepted, and falls on the edge that accepts it.
- R11: With `tx_ready_i` held high, the block sends one byte per clock, so the whole stream takes exactly as many valid cycles as it has bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Metadata request strobe |
| tx_ready_i | input | 1 | Downstream accepts the current byte |
| tx_data_o | output | 8 | Byte being offered |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to send |
| busy_o | output | 1 | A response is in progress |

## Verification
Some rules are checked by assertions on every cycle. Nothing is offered while idle. An idle request starts with key 0x01. The offered byte holds still under back-pressure. The response never ends without a handshake, and it only ends on a handshake of a zero byte. Whether the stream carries the right bytes in the right order cannot be expressed that way. The directed scenarios compare every accepted byte against a list built from the requirements, under full-rate, alternating and irregular ready patterns. They also inject a request in the middle of a response and count valid cycles to show one byte per clock.

// File: rtl/meta_pkg.sv
package meta_pkg;

  typedef enum logic [2:0] {
    VT_STR = 3'd0,
    VT_W32 = 3'd1,
    VT_W8  = 3'd2
  } val_type_e;

  localparam int N_STR = 3;
  localparam int N_W32 = 5;
  localparam int N_W8  = 2;
  // text records, wide integers, narrow integers, one terminator
  localparam int N_REC = N_STR + N_W32 + N_W8 + 1;
  localparam int REC_W = $clog2(N_REC);

  function automatic logic [7:0] mk_key(val_type_e t, int tok);
    return {t, 5'(tok)};
  endfunction

endpackage

// File: rtl/meta_rec_table.sv
module meta_rec_table
  import meta_pkg::*;
#(
  parameter int          REC_W_P     = 4,
  parameter int          POS_W       = 4,
  parameter int          NAME_LEN    = 7,
  parameter int          FPGA_LEN    = 4,
  parameter int          AUX_LEN     = 3,
  parameter logic [8*NAME_LEN-1:0] NAME_STR = "SNIFF32",
  parameter logic [8*FPGA_LEN-1:0] FPGA_STR = "3.07",
  parameter logic [8*AUX_LEN-1:0]  AUX_STR  = "0.9",
  parameter logic [31:0] PROBES      = 32'd32,
  parameter logic [31:0] SMEM_BYTES  = 32'd24576,
  parameter logic [31:0] DMEM_BYTES  = 32'd0,
  parameter logic [31:0] MAX_RATE_HZ = 32'd200000000,
  parameter logic [31:0] PROTO_VER   = 32'd2
) (
  input  logic [REC_W_P-1:0] rec_i,
  input  logic [POS_W-1:0]   pos_i,
  output logic [7:0]         byte_o,
  output logic               last_o
);

  localparam logic [31:0] W32_V [N_W32] =
    '{PROBES, SMEM_BYTES, DMEM_BYTES, MAX_RATE_HZ, PROTO_VER};
  localparam int W32_BASE = N_STR;
  localparam int W8_BASE  = N_STR + N_W32;
  localparam int TERM_REC = N_REC - 1;

  int         r;
  int         p;
  int         rr;
  int         s_len;
  logic [7:0] s_ch;
  logic [7:0] name_ch;
  logic [7:0] fpga_ch;
  logic [7:0] aux_ch;
  logic [31:0] w32;

  // one character per text field at the current position, zero past the end
  always_comb begin
    p = int'(pos_i);
    name_ch = 8'h00;
    fpga_ch = 8'h00;
    aux_ch  = 8'h00;
    if (p >= 1 && p <= NAME_LEN) name_ch = NAME_STR[8*(NAME_LEN-p) +: 8];
    if (p >= 1 && p <= FPGA_LEN) fpga_ch = FPGA_STR[8*(FPGA_LEN-p) +: 8];
    if (p >= 1 && p <= AUX_LEN)  aux_ch  = AUX_STR[8*(AUX_LEN-p) +: 8];
  end

  always_comb begin
    r      = int'(rec_i);
    rr     = 0;
    s_len  = 0;
    s_ch   = 8'h00;
    w32    = 32'h0;
    byte_o = 8'h00;
    last_o = 1'b0;
    if (r < W32_BASE) begin
      case (r)
        0:       begin s_len = NAME_LEN; s_ch = name_ch; end
        1:       begin s_len = FPGA_LEN; s_ch = fpga_ch; end
        default: begin s_len = AUX_LEN;  s_ch = aux_ch;  end
      endcase
      byte_o = (p == 0) ? mk_key(VT_STR, r + 1) : s_ch;
      last_o = (p == s_len + 1);
    end else if (r < W8_BASE) begin
      rr  = r - W32_BASE;
      w32 = W32_V[rr];
      if (p == 0) byte_o = mk_key(VT_W32, rr);
      else if (p <= 4) byte_o = w32[8*(4-p) +: 8];
      last_o = (p == 4);
    end else if (r < TERM_REC) begin
      rr = r - W8_BASE;
      if (p == 0) byte_o = mk_key(VT_W8, rr);
      else byte_o = (rr == 0) ? PROBES[7:0] : PROTO_VER[7:0];
      last_o = (p == 1);
    end else begin
      byte_o = 8'h00;
      last_o = 1'b1;
    end
  end

endmodule

// File: rtl/meta_seq.sv
module meta_seq
  import meta_pkg::*;
#(
  parameter int REC_W_P = 4,
  parameter int POS_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               req_i,
  input  logic               tx_ready_i,
  input  logic [7:0]         tbl_byte_i,
  input  logic               tbl_last_i,
  output logic [REC_W_P-1:0] nxt_rec_o,
  output logic [POS_W-1:0]   nxt_pos_o,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  output logic               busy_o
);

  localparam logic [REC_W_P-1:0] LAST_REC = REC_W_P'(N_REC - 1);

  logic [REC_W_P-1:0] rec_q;
  logic [POS_W-1:0]   pos_q;
  logic               last_q;
  logic               busy_q;
  logic               valid_q;
  logic [7:0]         data_q;
  logic               take;
  logic               at_end;

  assign take   = valid_q && tx_ready_i;
  assign at_end = last_q && (rec_q == LAST_REC);

  // index of the byte to load after the one now on offer
  always_comb begin
    if (!busy_q) begin
      nxt_rec_o = '0;
      nxt_pos_o = '0;
    end else if (last_q) begin
      nxt_rec_o = rec_q + 1'b1;
      nxt_pos_o = '0;
    end else begin
      nxt_rec_o = rec_q;
      nxt_pos_o = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rec_q   <= '0;
      pos_q   <= '0;
      last_q  <= 1'b0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= 8'h00;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q  <= 1'b1;
        valid_q <= 1'b1;
        rec_q   <= nxt_rec_o;
        pos_q   <= nxt_pos_o;
        data_q  <= tbl_byte_i;
        last_q  <= tbl_last_i;
      end
    end else if (take) begin
      if (at_end) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        rec_q  <= nxt_rec_o;
        pos_q  <= nxt_pos_o;
        data_q <= tbl_byte_i;
        last_q <= tbl_last_i;
      end
    end
  end

  assign tx_data_o  = data_q;
  assign tx_valid_o = valid_q;
  assign busy_o     = busy_q;

endmodule

// File: rtl/meta_resp_gen.sv
module meta_resp_gen
  import meta_pkg::*;
#(
  parameter int          NAME_LEN    = 7,
  parameter int          FPGA_LEN    = 4,
  parameter int          AUX_LEN     = 3,
  parameter logic [8*NAME_LEN-1:0] NAME_STR = "SNIFF32",
  parameter logic [8*FPGA_LEN-1:0] FPGA_STR = "3.07",
  parameter logic [8*AUX_LEN-1:0]  AUX_STR  = "0.9",
  parameter logic [31:0] PROBES      = 32'd32,
  parameter logic [31:0] SMEM_BYTES  = 32'd24576,
  parameter logic [31:0] DMEM_BYTES  = 32'd0,
  parameter logic [31:0] MAX_RATE_HZ = 32'd200000000,
  parameter logic [31:0] PROTO_VER   = 32'd2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       req_i,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  output logic       busy_o
);

  localparam int MAX_A   = (NAME_LEN > FPGA_LEN) ? NAME_LEN : FPGA_LEN;
  localparam int MAX_B   = (MAX_A > AUX_LEN) ? MAX_A : AUX_LEN;
  localparam int MAX_LEN = (MAX_B > 4) ? MAX_B : 4;
  localparam int POS_W   = $clog2(MAX_LEN + 2);

  logic [REC_W-1:0] nxt_rec;
  logic [POS_W-1:0] nxt_pos;
  logic [7:0]       tbl_byte;
  logic             tbl_last;

  meta_seq #(
    .REC_W_P (REC_W),
    .POS_W   (POS_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .req_i      (req_i),
    .tx_ready_i (tx_ready_i),
    .tbl_byte_i (tbl_byte),
    .tbl_last_i (tbl_last),
    .nxt_rec_o  (nxt_rec),
    .nxt_pos_o  (nxt_pos),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .busy_o     (busy_o)
  );

  meta_rec_table #(
    .REC_W_P     (REC_W),
    .POS_W       (POS_W),
    .NAME_LEN    (NAME_LEN),
    .FPGA_LEN    (FPGA_LEN),
    .AUX_LEN     (AUX_LEN),
    .NAME_STR    (NAME_STR),
    .FPGA_STR    (FPGA_STR),
    .AUX_STR     (AUX_STR),
    .PROBES      (PROBES),
    .SMEM_BYTES  (SMEM_BYTES),
    .DMEM_BYTES  (DMEM_BYTES),
    .MAX_RATE_HZ (MAX_RATE_HZ),
    .PROTO_VER   (PROTO_VER)
  ) u_tbl (
    .rec_i  (nxt_rec),
    .pos_i  (nxt_pos),
    .byte_o (tbl_byte),
    .last_o (tbl_last)
  );

endmodule

// File: rtl/meta_resp_gen_chk.sv
module meta_resp_gen_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       req_i,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       busy_o
);

  // R1: nothing offered while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> !tx_valid_o);

  // R2: idle request starts with the device-name key
  a_r2_start_key: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && req_i) |=> (busy_o && tx_valid_o && tx_data_o == 8'h01));

  // R8: offered byte held under back-pressure
  a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R9: a response cannot stop or restart without a handshake
  a_r9_no_drop: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && !(tx_valid_o && tx_ready_i)) |=> busy_o);

  // R10: the response only ends after a zero byte is accepted
  a_r10_end_on_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> $past(tx_valid_o && tx_ready_i && tx_data_o == 8'h00));

endmodule

bind meta_resp_gen meta_resp_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .req_i      (req_i),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .busy_o     (busy_o)
);

// File: tb/meta_resp_gen_tb_top.sv
module meta_resp_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       rdy = 1'b0;
  logic [7:0] data;
  logic       valid;
  logic       busy;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] exp_b [0:63];
  string      exp_t [0:63];
  int         n_exp = 0;
  logic [7:0] lfsr  = 8'hA5;

  always #10 clk = ~clk;

  meta_resp_gen dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .req_i      (req),
    .tx_ready_i (rdy),
    .tx_data_o  (data),
    .tx_valid_o (valid),
    .busy_o     (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_b[n_exp] = b;
    exp_t[n_exp] = tag;
    n_exp++;
  endtask

  task automatic push_str(input logic [7:0] key, input string s);
    push(key, "R3");
    for (int i = 0; i < s.len(); i++) push(s[i], "R4");
    push(8'h00, "R4");
  endtask

  task automatic push_w32(input logic [7:0] key, input logic [31:0] v);
    push(key, "R5");
    for (int i = 3; i >= 0; i--) push(v[8*i +: 8], "R5");
  endtask

  task automatic push_w8(input logic [7:0] key, input logic [7:0] v);
    push(key, "R6");
    push(v, "R6");
  endtask

  task automatic build_expected();
    n_exp = 0;
    push_str(8'h01, "SNIFF32");
    push_str(8'h02, "3.07");
    push_str(8'h03, "0.9");
    push_w32(8'h20, 32'd32);
    push_w32(8'h21, 32'd24576);
    push_w32(8'h22, 32'd0);
    push_w32(8'h23, 32'd200000000);
    push_w32(8'h24, 32'd2);
    push_w8(8'h40, 8'd32);
    push_w8(8'h41, 8'd2);
    push(8'h00, "R7");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!valid, "R1 valid in reset", int'(valid), 0);
    chk(!busy, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!valid && !busy, "R1 idle after reset", int'({valid, busy}), 0);
  endtask

  // mode 0: ready always high; 1: alternating; 2: pseudo-random
  task automatic t_stream(input int mode, input bit inject);
    int   idx = 0;
    int   vcyc = 0;
    int   cyc = 0;
    bit   stall = 1'b0;
    logic [7:0] pdata = 8'h00;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(valid && busy && data == 8'h01, "R2 start", int'(data), 1);
    while (busy && cyc < 1000) begin
      cyc++;
      req = 1'b0;
      if (valid) begin
        vcyc++;
        if (stall) chk(data == pdata, "R8 hold", int'(data), int'(pdata));
        case (mode)
          0:       rdy = 1'b1;
          1:       rdy = cyc[0];
          default: rdy = lfsr[0] | lfsr[3];
        endcase
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rdy) begin
          if (idx < n_exp)
            chk(data == exp_b[idx], exp_t[idx], int'(data), int'(exp_b[idx]));
          else
            chk(1'b0, "R7 extra byte", int'(data), 0);
          idx++;
        end
        if (inject && (idx == 12 || idx == 40)) req = 1'b1; // R9
        stall = !rdy;
        pdata = data;
      end else begin
        chk(1'b0, "R10 busy without valid", int'(valid), 1);
      end
      @(negedge clk);
    end
    req = 1'b0;
    rdy = 1'b0;
    chk(idx == n_exp, inject ? "R9 stream length" : "R10 stream length", idx, n_exp);
    chk(!busy && !valid, "R10 idle after end", int'({busy, valid}), 0);
    if (mode == 0) chk(vcyc == n_exp, "R11 one byte per clock", vcyc, n_exp);
    repeat (3) @(negedge clk);
    chk(!valid && !busy, "R1 stays idle", int'({valid, busy}), 0);
  endtask

  initial begin
    build_expected();
    t_reset();
    t_stream(0, 1'b0);
    t_stream(1, 1'b0);
    t_stream(2, 1'b0);
    t_stream(0, 1'b1);
    t_stream(2, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule